// File: doc/BRIEF.md
# Internal Data Space Access Router

This block sits between an 8-bit controller core and its on-chip data storage. Every data-space access the core makes arrives here as an 8-bit address, an addressing mode and a read or write strobe. The router decides whether the access lands in a 256-byte RAM that the block owns, in the stack-pointer register that the block also owns, or on a narrow port towards the special-function registers that live in peripheral blocks. The upper half of the address range carries two separate stores. Direct accesses there reach the register port. Indirect accesses there reach the upper half of the RAM.

Three further address forms are resolved in the same place. A working-register access names one of eight registers, and the two bank-select bits place it in the bottom 32 bytes of RAM. A single-bit access names one of 256 bits: the lower 128 live in a 16-byte window of RAM and the upper 128 live in the register bytes whose addresses are multiples of eight. Push and pop strobes move the stack pointer and reach RAM by indirect addressing, so the stack may grow past 7Fh. A bit write is a read-modify-write that completes in one clock. Read results appear one clock after the request.

Top module: `idmem_router`

## Requirements
- R1: After reset `rd_valid` is 0, and the stack pointer reads back as 07h through a direct read of address 81h. RAM contents are not set by reset.
- R2: Mode 0 (direct) with an address below 80h, and mode 1 (indirect) with any address, read and write the RAM byte at that address. Addresses below 80h reach the same byte in both modes.
- R3: Mode 0 with an address at or above 80h, other than 81h, reaches the register port: `sfr_addr` carries the address, `sfr_rd` or `sfr_wr` pulses in the same cycle, and RAM is untouched. Mode 1 never strobes the register port. The two stores at the same upper address stay independent.
- R4: A register read while `sfr_hit` is low returns 00h. A register write while `sfr_hit` is low leaves every RAM byte unchanged.
- R5: Mode 2 (working register) reaches RAM byte {bank_sel[1:0], acc_addr[2:0]}. Address bits 7..3 are ignored.
- R6: Mode 3 (bit) with a bit address b below 80h reaches RAM byte 20h + b[6:3], bit b[2:0]. A bit read returns that bit on `rd_bit` and the whole byte on `rd_data`. A bit write changes only that bit and completes in one cycle.
- R7: Mode 3 with b at or above 80h reaches register byte {b[7:3], 000}. A bit write raises `sfr_rd` and `sfr_wr` together, and `sfr_wdata` is `sfr_rdata` with bit b[2:0] replaced by `wr_bit`.
- R8: The stack pointer at 81h is held inside the block. Direct reads and writes of 81h go to it, and the register port is never strobed for 81h.
- R9: A push increments the stack pointer and then writes `wr_data` at the new value. A pop returns the byte at the current stack pointer and then decrements it. Both wrap modulo 256, and both reach the upper RAM, never the register port.
- R10: One operation is taken per cycle, with priority push > pop > write > read. `rd_valid` is high in the cycle after an accepted read or pop, and low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_mode | input | 2 | 0 direct, 1 indirect, 2 working register, 3 bit |
| acc_addr | input | 8 | Byte address, register number or bit address |
| bank_sel | input | 2 | Working-register bank |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| wr_data | input | 8 | Byte write data, also push data |
| wr_bit | input | 1 | Bit write value |
| push_req | input | 1 | Stack push |
| pop_req | input | 1 | Stack pop |
| rd_data | output | 8 | Read result, one cycle after the request |
| rd_bit | output | 1 | Bit read result |
| rd_valid | output | 1 | Read result present |
| sfr_addr | output | 8 | Register port address |
| sfr_rd | output | 1 | Register port read strobe |
| sfr_wr | output | 1 | Register port write strobe |
| sfr_wdata | output | 8 | Register port write data |
| sfr_rdata | input | 8 | Register port read data, same cycle |
| sfr_hit | input | 1 | Addressed register is implemented |

## Verification
The assertions watch every cycle for port-level routing rules: indirect, working-register and low direct accesses never strobe the register port, the stack-pointer address never appears on that port, upper bit writes strobe both directions on an aligned address, push and pop move the stack pointer by one, and `rd_valid` follows the accepted reads. Only the bench's scenarios can show that data ends up in the right byte. This covers the two stores at one upper address holding different values, bank and bit-address mapping, unimplemented registers reading as zero, and stack wrap-around. The bench shows this by reading back through the normal interface and comparing against its own model.

// File: rtl/idmem_pkg.sv
// Shared types for the internal data space router.
// Assumes: the 2-bit mode code is fixed by the core's decode stage.
package idmem_pkg;
    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_WREG     = 2'd2,
        AM_BIT      = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        DST_RAM  = 2'd0,
        DST_SFR  = 2'd1,
        DST_SP   = 2'd2,
        DST_NONE = 2'd3
    } dest_e;
endpackage

// File: rtl/idmem_decode.sv
// Address resolver: turns mode, address and bank into a destination store,
// a byte address inside it and a bit index.
// Assumes: AW >= 6, DW is a power of two, BIT_BASE leaves room for the window.
module idmem_decode
    import idmem_pkg::*;
#(
    parameter int unsigned AW       = 8,
    parameter int unsigned DW       = 8,
    parameter logic [AW-1:0] BIT_BASE = 'h20,
    parameter logic [AW-1:0] SP_ADDR  = 'h81,
    localparam int unsigned IW = $clog2(DW)
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    bank,
    output dest_e         dst,
    output logic [AW-1:0] byte_addr,
    output logic [IW-1:0] bit_idx
);
    localparam int unsigned HI = AW - 1;

    // Pick store and byte address for each addressing mode.
    always_comb begin
        dst       = DST_RAM;
        byte_addr = addr;
        bit_idx   = addr[IW-1:0];
        unique case (acc_mode_e'(mode))
            AM_DIRECT: begin
                if (addr[HI]) dst = (addr == SP_ADDR) ? DST_SP : DST_SFR;
            end
            AM_INDIRECT: begin
                dst = DST_RAM;
            end
            AM_WREG: begin
                byte_addr = {{(AW-5){1'b0}}, bank, addr[2:0]};
            end
            AM_BIT: begin
                if (addr[HI]) begin
                    dst       = DST_SFR;
                    byte_addr = {addr[HI:IW], {IW{1'b0}}};
                end else begin
                    byte_addr = BIT_BASE + AW'(addr[HI-1:IW]);
                end
            end
            default: dst = DST_NONE;
        endcase
    end
endmodule

// File: rtl/idmem_bitmerge.sv
// Replaces one bit of a byte; used for single-cycle bit read-modify-write.
// Assumes: idx always names a bit inside the byte.
module idmem_bitmerge #(
    parameter int unsigned DW = 8,
    localparam int unsigned IW = $clog2(DW)
) (
    input  logic [DW-1:0] byte_in,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic [DW-1:0] byte_out
);
    // One selector per bit lane.
    for (genvar i = 0; i < DW; i++) begin : g_lane
        assign byte_out[i] = (idx == IW'(i)) ? bit_in : byte_in[i];
    end
endmodule

// File: rtl/idmem_store.sv
// Data RAM: one asynchronous read port and one synchronous write port.
// Assumes: contents are left uninitialised by reset on purpose.
module idmem_store #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read is combinational so a merge can complete in the same cycle.
    assign rdata = mem[raddr];
endmodule

// File: rtl/idmem_stack.sv
// Stack pointer register with load, increment and decrement.
// Assumes: the caller applies at most one of load, inc and dec per cycle.
module idmem_stack #(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] SP_RESET = 'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic          dec,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_up
);
    assign sp_up = sp + AW'(1);

    // Update the pointer; wraps modulo 2**AW.
    always_ff @(posedge clk) begin
        if (!rst_n)     sp <= SP_RESET;
        else if (inc)   sp <= sp_up;
        else if (dec)   sp <= sp - AW'(1);
        else if (load)  sp <= load_val;
    end
endmodule

// File: rtl/idmem_router.sv
// Internal data space router: arbitrates one operation per cycle, resolves
// it to RAM, stack pointer or register port, merges bit writes, and
// registers read results.
// Assumes: the register port answers sfr_rdata/sfr_hit in the same cycle.
module idmem_router
    import idmem_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned DW         = 8,
    parameter logic [AW-1:0] SP_ADDR  = 'h81,
    parameter logic [AW-1:0] SP_RESET = 'h07,
    parameter logic [AW-1:0] BIT_BASE = 'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    acc_mode,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    bank_sel,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_bit,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_bit,
    output logic          rd_valid,
    output logic [AW-1:0] sfr_addr,
    output logic          sfr_rd,
    output logic          sfr_wr,
    output logic [DW-1:0] sfr_wdata,
    input  logic [DW-1:0] sfr_rdata,
    input  logic          sfr_hit
);
    localparam int unsigned IW = $clog2(DW);

    dest_e         dst;
    logic [AW-1:0] dec_addr;
    logic [IW-1:0] dec_bit;
    logic          do_push, do_pop, do_wr, do_rd, bit_mode;
    logic [AW-1:0] sp_q, sp_up;
    logic [AW-1:0] ram_raddr, ram_waddr;
    logic [DW-1:0] ram_rdata, ram_wdata, ram_merged;
    logic          ram_we;
    logic [DW-1:0] sfr_merged, sfr_view, src_byte;

    // Fixed priority: push, pop, write, read.
    always_comb begin
        do_push  = push_req;
        do_pop   = pop_req && !push_req;
        do_wr    = wr_req && !push_req && !pop_req;
        do_rd    = rd_req && !wr_req && !push_req && !pop_req;
        bit_mode = (acc_mode_e'(acc_mode) == AM_BIT);
    end

    idmem_decode #(.AW(AW), .DW(DW), .BIT_BASE(BIT_BASE), .SP_ADDR(SP_ADDR)) u_decode (
        .mode      (acc_mode),
        .addr      (acc_addr),
        .bank      (bank_sel),
        .dst       (dst),
        .byte_addr (dec_addr),
        .bit_idx   (dec_bit)
    );

    idmem_stack #(.AW(AW), .SP_RESET(SP_RESET)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_wr && dst == DST_SP),
        .load_val (AW'(wr_data)),
        .inc      (do_push),
        .dec      (do_pop),
        .sp       (sp_q),
        .sp_up    (sp_up)
    );

    // RAM port steering: stack uses the pointer, everything else the decode.
    always_comb begin
        ram_raddr = do_pop ? sp_q : dec_addr;
        ram_we    = do_push || (do_wr && dst == DST_RAM);
        ram_waddr = do_push ? sp_up : dec_addr;
        ram_wdata = (!do_push && bit_mode) ? ram_merged : wr_data;
    end

    idmem_store #(.AW(AW), .DW(DW)) u_store (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    idmem_bitmerge #(.DW(DW)) u_ram_merge (
        .byte_in  (ram_rdata),
        .idx      (dec_bit),
        .bit_in   (wr_bit),
        .byte_out (ram_merged)
    );

    idmem_bitmerge #(.DW(DW)) u_sfr_merge (
        .byte_in  (sfr_rdata),
        .idx      (dec_bit),
        .bit_in   (wr_bit),
        .byte_out (sfr_merged)
    );

    // Register port strobes; a bit write reads and writes in one cycle.
    always_comb begin
        sfr_addr  = dec_addr;
        sfr_rd    = (dst == DST_SFR) && (do_rd || (do_wr && bit_mode));
        sfr_wr    = (dst == DST_SFR) && do_wr;
        sfr_wdata = bit_mode ? sfr_merged : wr_data;
    end

    // Select the byte a read or pop returns; absent registers read as zero.
    always_comb begin
        sfr_view = sfr_hit ? sfr_rdata : '0;
        if (do_pop) src_byte = ram_rdata;
        else begin
            unique case (dst)
                DST_RAM: src_byte = ram_rdata;
                DST_SFR: src_byte = sfr_view;
                DST_SP:  src_byte = DW'(sp_q);
                default: src_byte = '0;
            endcase
        end
    end

    // Register read results one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= do_rd || do_pop;
            if (do_rd || do_pop) begin
                rd_data <= src_byte;
                rd_bit  <= (do_rd && bit_mode) ? src_byte[dec_bit] : 1'b0;
            end
        end
    end
endmodule

// File: rtl/idmem_router_chk.sv
// Cycle-by-cycle routing checks for idmem_router, attached with bind.
module idmem_router_chk #(
    parameter int unsigned AW        = 8,
    parameter logic [AW-1:0] SP_ADDR = 'h81
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    acc_mode,
    input logic [AW-1:0] acc_addr,
    input logic          rd_req,
    input logic          wr_req,
    input logic          push_req,
    input logic          pop_req,
    input logic          rd_valid,
    input logic [AW-1:0] sfr_addr,
    input logic          sfr_rd,
    input logic          sfr_wr,
    input logic [AW-1:0] sp_q
);
    // R2: low direct addresses stay in RAM.
    a_r2_low_direct_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'd0 && !acc_addr[AW-1]) |-> (!sfr_rd && !sfr_wr));

    // R3: indirect mode never reaches the register port.
    a_r3_indirect_no_port: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'd1) |-> (!sfr_rd && !sfr_wr));

    // R5: working registers live in RAM.
    a_r5_wreg_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'd2) |-> (!sfr_rd && !sfr_wr));

    // R7: upper bit write strobes both directions on an aligned byte.
    a_r7_bit_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'd3 && acc_addr[AW-1] && wr_req && !push_req && !pop_req)
        |-> (sfr_rd && sfr_wr && sfr_addr[2:0] == 3'd0));

    // R8: the stack pointer address never appears on the port.
    a_r8_sp_private: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd || sfr_wr) |-> (sfr_addr != SP_ADDR));

    // R9: push and pop step the pointer by one.
    a_r9_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> (sp_q == $past(sp_q) + AW'(1)));
    a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req) |=> (sp_q == $past(sp_q) - AW'(1)));

    // R10: read result timing.
    a_r10_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_req && !push_req && !pop_req) |=> rd_valid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !pop_req) |=> !rd_valid);
endmodule

bind idmem_router idmem_router_chk #(.AW(AW), .SP_ADDR(SP_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_mode (acc_mode),
    .acc_addr (acc_addr),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .push_req (push_req),
    .pop_req  (pop_req),
    .rd_valid (rd_valid),
    .sfr_addr (sfr_addr),
    .sfr_rd   (sfr_rd),
    .sfr_wr   (sfr_wr),
    .sp_q     (sp_q)
);

// File: tb/idmem_router_test.sv
module idmem_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_mode = '0;
    logic [7:0] acc_addr = '0;
    logic [1:0] bank_sel = '0;
    logic       rd_req = 1'b0, wr_req = 1'b0, wr_bit = 1'b0;
    logic       push_req = 1'b0, pop_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;
    logic       rd_bit, rd_valid, sfr_rd, sfr_wr, sfr_hit;

    logic [7:0] periph  [256];
    logic [7:0] exp_ram [256];
    logic [7:0] exp_sfr [256];
    logic [7:0] exp_sp;
    int n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    idmem_router uut (
        .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode), .acc_addr(acc_addr),
        .bank_sel(bank_sel), .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
        .wr_bit(wr_bit), .push_req(push_req), .pop_req(pop_req),
        .rd_data(rd_data), .rd_bit(rd_bit), .rd_valid(rd_valid),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit)
    );

    // Peripheral register model: addresses ending in Fh are absent.
    assign sfr_rdata = periph[sfr_addr];
    assign sfr_hit   = (sfr_addr[3:0] != 4'hF);
    always @(posedge clk) if (sfr_wr && sfr_hit) periph[sfr_addr] <= sfr_wdata;

    function automatic bit hit_of(input logic [7:0] a);
        return a[3:0] != 4'hF;
    endfunction

    function automatic logic [7:0] merge(input logic [7:0] v, input logic [2:0] i, input logic b);
        logic [7:0] r = v;
        r[i] = b;
        return r;
    endfunction

    // dst: 0 RAM, 1 register port, 2 stack pointer
    function automatic void resolve(input logic [1:0] m, input logic [7:0] a, input logic [1:0] bk,
                                    output int dst, output logic [7:0] ba);
        dst = 0; ba = a;
        case (m)
            2'd0: if (a == 8'h81) dst = 2; else if (a >= 8'h80) dst = 1;
            2'd2: ba = {3'b000, bk, a[2:0]};
            2'd3: if (a[7]) begin dst = 1; ba = {a[7:3], 3'b000}; end
                  else ba = 8'h20 + {4'h0, a[6:3]};
            default: ;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic op(input string tag, input logic [1:0] m, input logic [7:0] a, input logic [1:0] bk,
                      input bit r, input bit w, input logic [7:0] d, input logic b,
                      input bit pu, input bit po);
        int dst;
        logic [7:0] ba, cur, val, nv;
        bit e_pu, e_po, e_w, e_r, e_srd, e_swr;
        e_pu = pu; e_po = po && !pu; e_w = w && !pu && !po; e_r = r && !w && !pu && !po;
        resolve(m, a, bk, dst, ba);
        cur = (dst == 0) ? exp_ram[ba] : (dst == 1) ? exp_sfr[ba] : exp_sp;
        e_srd = (dst == 1) && (e_r || (e_w && m == 2'd3));
        e_swr = (dst == 1) && e_w;
        @(negedge clk);
        acc_mode = m; acc_addr = a; bank_sel = bk; rd_req = r; wr_req = w;
        wr_data = d; wr_bit = b; push_req = pu; pop_req = po;
        #2;
        chk(tag, "sfr_rd", sfr_rd, e_srd);
        chk(tag, "sfr_wr", sfr_wr, e_swr);
        if (e_srd || e_swr) chk(tag, "sfr_addr", sfr_addr, ba);
        if (e_swr) chk(tag, "sfr_wdata", sfr_wdata, (m == 2'd3) ? merge(cur, a[2:0], b) : d);
        @(negedge clk);
        rd_req = 0; wr_req = 0; push_req = 0; pop_req = 0;
        chk(tag, "rd_valid", rd_valid, e_r || e_po);
        if (e_po) chk(tag, "pop data", rd_data, exp_ram[exp_sp]);
        if (e_r) begin
            val = (dst == 1 && !hit_of(ba)) ? 8'h00 : cur;
            chk(tag, "rd_data", rd_data, val);
            if (m == 2'd3) chk(tag, "rd_bit", rd_bit, val[a[2:0]]);
        end
        if (e_pu) begin exp_sp = exp_sp + 8'd1; exp_ram[exp_sp] = d; end
        else if (e_po) exp_sp = exp_sp - 8'd1;
        else if (e_w) begin
            nv = (m == 2'd3) ? merge(cur, a[2:0], b) : d;
            if (dst == 0) exp_ram[ba] = nv;
            else if (dst == 1) begin if (hit_of(ba)) exp_sfr[ba] = nv; end
            else exp_sp = nv;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        v = 8'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            v = 8'($urandom);
            periph[i] = v; exp_sfr[i] = v; exp_ram[i] = 8'h00;
        end
        exp_sp = 8'h07;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "rd_valid after reset", rd_valid, 1'b0);
        op("R1", 2'd0, 8'h81, 2'd0, 1, 0, 8'h00, 0, 0, 0);      // SP reads 07h
        // Fill RAM through indirect writes (R2)
        for (int i = 0; i < 256; i++) op("R2", 2'd1, 8'(i), 2'd0, 0, 1, 8'($urandom), 0, 0, 0);
        op("R2", 2'd0, 8'h30, 2'd0, 0, 1, 8'h5C, 0, 0, 0);
        op("R2", 2'd1, 8'h30, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        // Same upper address in both modes holds two values (R3)
        op("R3", 2'd0, 8'h90, 2'd0, 0, 1, 8'hAA, 0, 0, 0);
        op("R3", 2'd1, 8'h90, 2'd0, 0, 1, 8'h55, 0, 0, 0);
        op("R3", 2'd0, 8'h90, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R3", 2'd1, 8'h90, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        // Absent register (R4)
        op("R4", 2'd0, 8'h8F, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R4", 2'd0, 8'h8F, 2'd0, 0, 1, 8'h3C, 0, 0, 0);
        op("R4", 2'd1, 8'h8F, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        // Working registers (R5)
        op("R5", 2'd2, 8'hFD, 2'd2, 0, 1, 8'hE7, 0, 0, 0);
        op("R5", 2'd1, 8'h15, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R5", 2'd2, 8'h05, 2'd2, 1, 0, 8'h00, 0, 0, 0);
        // Bit access in RAM window (R6) and register bytes (R7)
        op("R6", 2'd3, 8'h0B, 2'd0, 0, 1, 8'h00, 1, 0, 0);
        op("R6", 2'd3, 8'h0B, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R6", 2'd3, 8'h7F, 2'd0, 0, 1, 8'h00, 0, 0, 0);
        op("R6", 2'd1, 8'h2F, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R7", 2'd3, 8'h93, 2'd0, 0, 1, 8'h00, 1, 0, 0);
        op("R7", 2'd0, 8'h90, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R7", 2'd3, 8'hFE, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        // Stack pointer and stack (R8, R9)
        op("R8", 2'd0, 8'h81, 2'd0, 0, 1, 8'h7F, 0, 0, 0);
        op("R9", 2'd0, 8'h00, 2'd0, 0, 0, 8'hC3, 0, 1, 0);
        op("R9", 2'd1, 8'h80, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R9", 2'd0, 8'h00, 2'd0, 0, 0, 8'h00, 0, 0, 1);
        op("R8", 2'd0, 8'h81, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R8", 2'd0, 8'h81, 2'd0, 0, 1, 8'hFF, 0, 0, 0);
        op("R9", 2'd0, 8'h00, 2'd0, 0, 0, 8'h99, 0, 1, 0);
        op("R9", 2'd1, 8'h00, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R9", 2'd0, 8'h00, 2'd0, 0, 0, 8'h00, 0, 0, 1);
        // Priority (R10)
        op("R10", 2'd1, 8'h40, 2'd0, 1, 1, 8'h4D, 0, 0, 0);
        op("R10", 2'd1, 8'h40, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        op("R10", 2'd1, 8'h41, 2'd0, 1, 1, 8'h6B, 0, 1, 1);
        op("R10", 2'd0, 8'h81, 2'd0, 1, 0, 8'h00, 0, 0, 0);
        // Random mix
        for (int k = 0; k < 600; k++) begin
            logic [1:0] m;
            logic [7:0] a;
            string t;
            m = 2'($urandom);
            a = 8'($urandom);
            case (m)
                2'd0: t = a[7] ? "R3" : "R2";
                2'd1: t = "R2";
                2'd2: t = "R5";
                default: t = a[7] ? "R7" : "R6";
            endcase
            op(t, m, a, 2'($urandom), 1'($urandom), ($urandom % 3) == 0, 8'($urandom),
               1'($urandom), ($urandom % 12) == 0, ($urandom % 12) == 0);
        end
        summary();
    end
endmodule